// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block drives the clock and data lines of a two-wire open-drain serial bus, one bus operation per command. A controller above it issues one of five operations: start condition, send a byte and sample the acknowledge, receive a byte and answer with ACK, receive a byte and answer with NACK, or stop condition. Each operation runs to completion and then reports with a one-cycle `done` pulse. The block never drives a line high. It only enables a low driver on each line, and it reads both lines back through a two-flop synchronizer.

The bit timing comes from a programmable divider. Every bit is built from four quarter periods. The clock is held low for the first and last quarter and released for the middle two. The high phase is timed only after the synchronized clock line reads high, so a slave that holds the clock low lengthens the bit. While sending, the block reads back every 1 bit it releases. If it finds the data line pulled low, another master has won the bus: the block lets go of both lines at once, ends the operation and raises a loss flag.

Top module: `i2c_byte_master`

## Requirements
- R1: While and after a synchronous reset, both drive-low outputs are 0, `busy`, `done`, `arb_lost`, `ack_received` are 0 and `rx_data` is 0.
- R2: `cmd` bit 0 selects start, bit 1 byte write, bit 2 byte read with ACK, bit 3 byte read with NACK, bit 4 stop. A command is taken only when `busy` is low and exactly one bit of `cmd` is set. Any other `cmd` value leaves `busy` low and both lines unchanged.
- R3: Start releases SDA with SCL low, releases SCL, then pulls SDA low while SCL is high, then pulls SCL low. Stop pulls SDA low with SCL low, releases SCL, then releases SDA while SCL is high, leaving both lines released.
- R4: A byte write sends `tx_data` most significant bit first, changing SDA only while SCL is driven low. It releases SDA for a ninth clock, and sets `ack_received` to 1 if SDA is low during that ninth high phase and to 0 otherwise.
- R5: A byte read releases SDA for eight clocks and collects the bits, first sampled into bit 7 of `rx_data`. On the ninth clock it pulls SDA low for the read-with-ACK command and leaves it released for read-with-NACK.
- R6: A quarter lasts `quarter_div`+1 clocks. Each bit also costs 3 clocks of line feedback latency, so without stretching an operation ends `done` B*(4*`quarter_div`+7) clocks after the accepting edge. B is 9 for a byte and 1 for start or stop. `quarter_div` must be at least 2.
- R7: The high phase of each bit is timed from when the synchronized SCL reads high. Every SCL high period lasts at least 2*(`quarter_div`+1) clocks, and a slave holding SCL low delays completion by at least the hold time per bit.
- R8: During a byte write, if the block releases SDA for a 1 bit and samples SDA low at the end of the high phase, then on the next clock both drive-low outputs are 0, `done` pulses and `arb_lost` is 1. `arb_lost` holds until the next accepted command. Sending a 0 bit over a low line is not a loss.
- R9: `busy` is high from the accepting edge until `done`. `done` is a single-cycle pulse. Commands presented while `busy` is high have no effect.
- R10: After start, write or read, the block keeps SCL driven low while idle until the next command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quarter_div | input | 16 | Quarter-period length minus one, in clocks |
| cmd | input | 5 | One-hot command strobe (start, write, read+ACK, read+NACK, stop) |
| tx_data | input | 8 | Byte to send on a write |
| scl_in | input | 1 | Clock line level as seen at the pad |
| sda_in | input | 1 | Data line level as seen at the pad |
| scl_drive_low | output | 1 | Enable for the clock line low driver |
| sda_drive_low | output | 1 | Enable for the data line low driver |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| rx_data | output | 8 | Last byte received |
| ack_received | output | 1 | Acknowledge seen after the last write |
| arb_lost | output | 1 | Last write ended on lost arbitration |

## Verification
A wrong quarter counter or bit index shows up on the lines within one bit period. The received byte is wrong, or the exact completion cycle count is off by a multiple of four quarters. A stuck stretch wait shows as a high phase shorter than two quarters, or as completion that does not slow down under a held clock. An arbitration fault is visible within one clock of the sample point: the drive enables stay on or the loss flag stays low. Ignored commands are checked at the lines and at `busy`, one clock and one full operation after the stray strobe.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

  localparam int CMD_W = 5;

  typedef enum logic [2:0] {
    OP_START,
    OP_WRITE,
    OP_READ_ACK,
    OP_READ_NACK,
    OP_STOP
  } bm_op_e;

  // Command bit position decides the operation (bit 0 start ... bit 4 stop).
  function automatic bm_op_e op_from_cmd(input logic [CMD_W-1:0] c);
    bm_op_e r;
    if (c[0])      r = OP_START;
    else if (c[1]) r = OP_WRITE;
    else if (c[2]) r = OP_READ_ACK;
    else if (c[3]) r = OP_READ_NACK;
    else           r = OP_STOP;
    return r;
  endfunction

endpackage

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  // Lines idle high, so every stage resets to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '1;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/i2c_bm_qtick.sv
module i2c_bm_qtick #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         hold,
  input  logic [W-1:0] limit,
  output logic         tick
);

  logic [W-1:0] cnt;

  assign tick = run && !hold && (cnt == limit);

  // Count freezes during hold so a stretched quarter restarts cleanly.
  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else if (!hold)   cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  quarter_div,
  input  logic [4:0]        cmd,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              ack_received,
  output logic              arb_lost
);

  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(DATA_W);

  logic [1:0] lines_s;
  logic       scl_s, sda_s;

  i2c_bm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  bm_op_e            op;
  logic [1:0]        qtr;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic              tick, hold;
  logic              accept, is_byte_op, last_bit, lose_now;
  logic              scl_n, sda_n, data_low;

  // Quarter 1 is the stretch wait: no counting until SCL is seen high.
  assign hold = busy && (qtr == 2'd1) && !scl_s;

  i2c_bm_qtick #(.W(DIV_W)) u_qtick (
    .clk   (clk),
    .rst   (rst),
    .run   (busy),
    .hold  (hold),
    .limit (quarter_div),
    .tick  (tick)
  );

  assign accept     = !busy && ($countones(cmd) == 1);
  assign is_byte_op = (op == OP_WRITE) || (op == OP_READ_ACK) || (op == OP_READ_NACK);
  assign last_bit   = is_byte_op ? (bitn == ACK_SLOT) : (bitn == '0);
  assign lose_now   = tick && (qtr == 2'd2) && (op == OP_WRITE) &&
                      (bitn != ACK_SLOT) && shreg[DATA_W-1] && !sda_s;

  always_comb begin
    if (bitn == ACK_SLOT)      data_low = (op == OP_READ_ACK);
    else if (op == OP_WRITE)   data_low = !shreg[DATA_W-1];
    else                       data_low = 1'b0;
  end

  // Line pattern per quarter: SCL low in quarters 0 and 3 for bits.
  always_comb begin
    case (op)
      OP_START: begin
        scl_n = (qtr == 2'd0) || (qtr == 2'd3);
        sda_n = (qtr == 2'd2) || (qtr == 2'd3);
      end
      OP_STOP: begin
        scl_n = (qtr == 2'd0);
        sda_n = (qtr == 2'd0) || (qtr == 2'd1);
      end
      default: begin
        scl_n = (qtr == 2'd0) || (qtr == 2'd3);
        sda_n = data_low;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op            <= OP_START;
      qtr           <= '0;
      bitn          <= '0;
      shreg         <= '0;
      busy          <= 1'b0;
      done          <= 1'b0;
      rx_data       <= '0;
      ack_received  <= 1'b0;
      arb_lost      <= 1'b0;
      scl_drive_low <= 1'b0;
      sda_drive_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (accept) begin
          busy     <= 1'b1;
          arb_lost <= 1'b0;
          op       <= op_from_cmd(cmd);
          qtr      <= '0;
          bitn     <= '0;
          shreg    <= tx_data;
        end
      end else begin
        scl_drive_low <= scl_n;
        sda_drive_low <= sda_n;
        if (tick) begin
          qtr <= qtr + 2'd1;
          if (qtr == 2'd2 && is_byte_op) begin
            if (bitn == ACK_SLOT) begin
              if (op == OP_WRITE) ack_received <= !sda_s;
            end else if (op != OP_WRITE) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
            end
          end
          if (qtr == 2'd3) begin
            if (last_bit) begin
              busy <= 1'b0;
              done <= 1'b1;
              if (op == OP_READ_ACK || op == OP_READ_NACK) rx_data <= shreg;
            end else begin
              bitn <= bitn + BIT_W'(1);
              if (op == OP_WRITE) shreg <= {shreg[DATA_W-2:0], 1'b0};
            end
          end
        end
        if (lose_now) begin
          busy          <= 1'b0;
          done          <= 1'b1;
          arb_lost      <= 1'b1;
          scl_drive_low <= 1'b0;
          sda_drive_low <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] cmd,
  input logic       busy,
  input logic       done,
  input logic       arb_lost,
  input logic       scl_drive_low,
  input logic       sda_drive_low,
  input logic [1:0] qtr,
  input logic       data_op,
  input logic       scl_seen
);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_bad_cmd_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && ($countones(cmd) != 1)) |=> !busy);

  assert_release_on_loss_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> (!scl_drive_low && !sda_drive_low && done));

  assert_sda_moves_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && data_op && !arb_lost && !$stable(sda_drive_low)) |->
      (scl_drive_low && $past(scl_drive_low)));

  assert_stretch_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && qtr == 2'd1 && !scl_seen) |=> (qtr == 2'd1));

endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd           (cmd),
  .busy          (busy),
  .done          (done),
  .arb_lost      (arb_lost),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .qtr           (qtr),
  .data_op       (is_byte_op),
  .scl_seen      (scl_s)
);

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;

  localparam logic [4:0] C_START = 5'b00001;
  localparam logic [4:0] C_WRITE = 5'b00010;
  localparam logic [4:0] C_RACK  = 5'b00100;
  localparam logic [4:0] C_RNACK = 5'b01000;
  localparam logic [4:0] C_STOP  = 5'b10000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] quarter_div = 16'd4;
  logic [4:0]  cmd = '0;
  logic [7:0]  tx_data = '0;
  logic        scl_drive_low, sda_drive_low, busy, done, ack_received, arb_lost;
  logic [7:0]  rx_data;
  logic        scl_line, sda_line;

  // Bench-side slave / other-master model
  int          slv_mode = 0;   // 0 release, 1 ack, 2 send rd_byte, 3 force low at force_idx
  logic [7:0]  rd_byte = '0;
  int          force_idx = 0;
  int          stretch_len = 0;
  logic        min_clr = 1'b0;
  logic        slv_scl_low, slv_sda_low;
  logic        prev_scl, prev_sda;
  int          bitcnt, st_cnt, start_seen, stop_seen, hi_cnt, min_hi;
  logic [7:0]  cap_byte;
  logic        cap_ack;

  int checks = 0, fails = 0, total_cyc = 0, last_cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign scl_line = !(scl_drive_low || slv_scl_low);
  assign sda_line = !(sda_drive_low || slv_sda_low);

  i2c_byte_master uut (
    .clk (clk), .rst (rst), .quarter_div (quarter_div), .cmd (cmd), .tx_data (tx_data),
    .scl_in (scl_line), .sda_in (sda_line),
    .scl_drive_low (scl_drive_low), .sda_drive_low (sda_drive_low),
    .busy (busy), .done (done), .rx_data (rx_data),
    .ack_received (ack_received), .arb_lost (arb_lost)
  );

  function automatic logic slave_drive(int mode, int idx, logic [7:0] rb, int fidx);
    case (mode)
      1: return idx == 8;
      2: return (idx < 8) ? !rb[7-idx] : 1'b0;
      3: return idx == fidx;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int op_cycles(int nbits, int dv);
    return nbits * (4 * dv + 7);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      slv_scl_low <= 1'b0; slv_sda_low <= 1'b0;
      prev_scl = 1'b1; prev_sda = 1'b1; bitcnt = 0; st_cnt = 0;
      start_seen = 0; stop_seen = 0; hi_cnt = 0; min_hi = 9999;
      cap_byte = '0; cap_ack = 1'b0;
    end else begin
      if (min_clr) min_hi = 9999;
      if (prev_scl && scl_line && prev_sda && !sda_line) begin start_seen++; bitcnt = 0; end
      if (prev_scl && scl_line && !prev_sda && sda_line) begin stop_seen++; bitcnt = 0; end
      if (!prev_scl && scl_line) begin
        if (bitcnt == 8) begin cap_ack = !sda_line; bitcnt = 0; end
        else begin cap_byte = {cap_byte[6:0], sda_line}; bitcnt++; end
      end
      if (scl_line) hi_cnt++;
      else if (prev_scl) begin
        if (hi_cnt < min_hi) min_hi = hi_cnt;
        hi_cnt = 0;
      end
      if (prev_scl && !scl_line && stretch_len > 0) begin
        slv_scl_low <= 1'b1; st_cnt = stretch_len;
      end else if (st_cnt > 0) begin
        st_cnt--;
        if (st_cnt == 0) slv_scl_low <= 1'b0;
      end
      if (!scl_line || slv_mode == 0) slv_sda_low <= slave_drive(slv_mode, bitcnt, rd_byte, force_idx);
      prev_scl = scl_line; prev_sda = sda_line;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      summary();
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [4:0] c, input logic [7:0] d);
    int n;
    @(negedge clk); cmd = c; tx_data = d;
    @(negedge clk); cmd = '0;
    chk("R9", "busy after accept", int'(busy), 1);
    n = 1;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    last_cycles = n;
    chk("R9", "done seen", int'(done), 1);
    @(negedge clk);
    chk("R9", "done single pulse", int'(done), 0);
  endtask

  task automatic chk_time(input int nbits);
    int e;
    e = op_cycles(nbits, int'(quarter_div)) + 1;
    chk("R6", "op cycles within 1", int'((last_cycles >= e - 1) && (last_cycles <= e + 1)), 1);
  endtask

  task automatic do_start();
    int s0;
    s0 = start_seen;
    run_op(C_START, 8'h00);
    chk_time(1);
    chk("R3", "start seen", start_seen - s0, 1);
    chk("R10", "scl held low after start", int'(scl_drive_low), 1);
  endtask

  task automatic do_stop();
    int s0;
    slv_mode = 0;
    s0 = stop_seen;
    run_op(C_STOP, 8'h00);
    chk_time(1);
    chk("R3", "stop seen", stop_seen - s0, 1);
    chk("R3", "lines high after stop", int'(scl_line && sda_line), 1);
  endtask

  task automatic do_write(input logic [7:0] d, input logic sack);
    slv_mode = sack ? 1 : 0;
    run_op(C_WRITE, d);
    chk_time(9);
    chk("R4", "byte on bus", int'(cap_byte), int'(d));
    chk("R4", "ack_received", int'(ack_received), int'(sack));
    chk("R10", "scl held low after write", int'(scl_drive_low), 1);
    slv_mode = 0;
  endtask

  task automatic do_read(input logic [7:0] rb, input logic give_ack);
    slv_mode = 2; rd_byte = rb;
    run_op(give_ack ? C_RACK : C_RNACK, 8'h00);
    slv_mode = 0;
    chk_time(9);
    chk("R5", "rx_data", int'(rx_data), int'(rb));
    chk("R5", "master ack level", int'(cap_ack), int'(give_ack));
  endtask

  initial begin
    int s0;
    repeat (4) @(negedge clk);
    chk("R1", "scl drive in reset", int'(scl_drive_low), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "sda drive", int'(sda_drive_low), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "flags", int'({done, arb_lost, ack_received}), 0);
    chk("R1", "rx_data", int'(rx_data), 0);

    // R2: bad command patterns ignored
    cmd = 5'b00011; @(negedge clk); cmd = 5'b11000; @(negedge clk); cmd = '0;
    @(negedge clk);
    chk("R2", "busy after bad cmd", int'(busy), 0);
    chk("R2", "lines after bad cmd", int'({scl_drive_low, sda_drive_low}), 0);

    // Directed transaction, quarter_div 4
    do_start();
    do_write(8'hA5, 1'b1);
    do_read(8'h3C, 1'b1);
    do_read(8'hC3, 1'b0);
    do_stop();

    // R9: stray command during an operation is ignored
    quarter_div = 16'd3;
    do_start();
    slv_mode = 1;
    @(negedge clk); cmd = C_WRITE; tx_data = 8'h96;
    @(negedge clk); cmd = '0;
    repeat (20) @(negedge clk);
    cmd = C_STOP; s0 = stop_seen;
    @(negedge clk); cmd = '0;
    while (!done) @(negedge clk);
    repeat (10) @(negedge clk);
    slv_mode = 0;
    chk("R9", "no stop during busy", stop_seen - s0, 0);
    chk("R9", "scl still held", int'(scl_drive_low), 1);
    chk("R9", "byte intact", int'(cap_byte), 8'h96);
    chk("R9", "still idle", int'(busy), 0);

    // R7: clock stretching
    min_clr = 1'b1; @(negedge clk); min_clr = 1'b0;
    stretch_len = 50;
    slv_mode = 1;
    run_op(C_WRITE, 8'h5A);
    stretch_len = 0; slv_mode = 0;
    repeat (60) @(negedge clk);
    chk("R7", "stretched op slower", int'(last_cycles >= 9 * 50), 1);
    chk("R7", "byte under stretch", int'(cap_byte), 8'h5A);
    chk("R7", "min high period", int'(min_hi >= 2 * (int'(quarter_div) + 1)), 1);
    do_stop();

    // R8: arbitration loss at bit index 2 (tx bit 5 = 1)
    do_start();
    slv_mode = 3; force_idx = 2;
    run_op(C_WRITE, 8'hA0);
    chk("R8", "arb_lost set", int'(arb_lost), 1);
    chk("R8", "lines released", int'({scl_drive_low, sda_drive_low}), 0);
    chk("R8", "early end", int'(last_cycles < op_cycles(9, int'(quarter_div))), 1);
    slv_mode = 0;
    repeat (5) @(negedge clk);
    chk("R8", "arb_lost held", int'(arb_lost), 1);
    do_start();
    chk("R8", "arb_lost cleared", int'(arb_lost), 0);
    // dominant over a 0 bit (index 1, tx bit 6 = 0) is no loss
    slv_mode = 3; force_idx = 1;
    run_op(C_WRITE, 8'hA0);
    slv_mode = 0;
    chk_time(9);
    chk("R8", "no loss on 0 bit", int'(arb_lost), 0);
    chk("R8", "byte complete", int'(cap_byte), 8'hA0);
    do_stop();

    // Random transactions
    void'($urandom(32'd20240611));
    for (int it = 0; it < 16; it++) begin
      logic [7:0] wb, rb;
      logic sa, ga;
      quarter_div = 16'(3 + ($urandom % 6));
      wb = 8'($urandom); rb = 8'($urandom);
      sa = 1'($urandom); ga = 1'($urandom);
      min_clr = 1'b1; @(negedge clk); min_clr = 1'b0;
      do_start();
      do_write(wb, sa);
      do_read(rb, ga);
      do_stop();
      chk("R7", "random min high", int'(min_hi >= 2 * (int'(quarter_div) + 1)), 1);
    end

    repeat (5) @(negedge clk);
    summary();
  end

endmodule